// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the frame, line and data strobes of a simulated area-scan camera, together with the horizontal and vertical position counts, once per pixel clock. A small write/read register port sets the raster geometry: the line length, the frame length and the number of active lines. It also sets a horizontal start and end position for each of three strobe windows: frame, line and read. The design does no division in the counter path. The active clock count per line is the programmed pixel width divided by a tap count, and it is formed once from configuration registers.

A window end written as zero selects a default end: the window start plus the active clock count. Two read-only registers return the horizontal and vertical blanking that the current geometry implies. A control register stops the raster. While stopped, the counts stay at zero and the strobes stay low. Writing the run value starts the raster again from the top of the frame.

Register addresses: 0 control (bit 3 = stop), 1 last horizontal count, 2 last active line, 3 last vertical count, 4/5 frame window start/end, 6/7 line window start/end, 8/9 read window start/end, 10 pixel width, 11 data path (tap field in bits 5:4), 12 mode (bit 0 = data strobe follows the read window), 13 horizontal blanking (read-only), 14 vertical blanking (read-only).

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal count steps by one each clock while running. After reaching the value in register 1 it wraps to 0, so a line is that value plus one clocks.
- R2: The vertical count advances once per line, when the horizontal count wraps. After the value in register 3 it wraps to 0.
- R3: Each window is active for horizontal counts h with start <= h < end. A window whose start is not below its effective end is never active.
- R4: A window end written as 0 takes the effective end start + A. A is the active clock count, the pixel width divided by the tap count (integer division).
- R5: The tap count is the data-path field in bits 5:4 plus one, so field values 0..3 give 1..4 taps.
- R6: The line strobe and the read strobe are asserted only on lines 0 up to and including the value in register 2, and only inside their own windows.
- R7: When the last active line is above 0, the frame strobe rises at the frame window start on line 0. It stays high through the intermediate lines and falls at the frame window end on the last active line. When the last active line is 0, the frame strobe is the frame window on line 0. It is never asserted when its window is empty.
- R8: The data strobe equals the read strobe when mode bit 0 is 1, and equals the line strobe when mode bit 0 is 0.
- R9: Register 13 reads back (register 1 + 1) − A. Register 14 reads back register 3 − register 2, which equals (frame lines) − (active lines).
- R10: After reset the generator is stopped (control reads 8). Writing a control value with bit 3 set stops it: both counts go to 0 and all strobes go low in the next cycle and stay there. Geometry writes made while stopped change no output until restart. A control write with bit 3 clear restarts the raster at count 0 on line 0 in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for write and read |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data at reg_addr_i |
| h_cnt_o | output | 12 | Horizontal count |
| v_cnt_o | output | 12 | Vertical count |
| fval_o | output | 1 | Frame strobe |
| lval_o | output | 1 | Line strobe |
| rval_o | output | 1 | Read strobe |
| dval_o | output | 1 | Data strobe |

## Verification
The counts are registers. A control write lands at one clock edge, and the bench sees the counts at 0/0 from the falling edge just after it. From then on it steps its own count model once per clock.

The strobes and the read data are combinational from registers. They are therefore compared in the same half cycle as the counts they belong to: strobes against a window model evaluated on the modelled counts, read data one time unit after the address settles.

After a stop write, the bench checks the zero counts and low strobes from the next falling edge on. It checks them again after geometry writes made while stopped.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_HMAX  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_VACT  = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_VMAX  = 4'd3;
  localparam int                WIN_BASE   = 4;   // start at base+2i, end at base+2i+1
  localparam logic [ADDR_W-1:0] ADDR_WIDTH = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_PATH  = 4'd11;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 4'd12;
  localparam logic [ADDR_W-1:0] ADDR_HBLK  = 4'd13;
  localparam logic [ADDR_W-1:0] ADDR_VBLK  = 4'd14;

  localparam int STOP_BIT  = 3;
  localparam int TAP_LSB   = 4;
  localparam int RVSEL_BIT = 0;

  localparam int NWIN   = 3;
  localparam int WIN_FV = 0;
  localparam int WIN_LV = 1;
  localparam int WIN_RV = 2;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int DW    = 16,
  parameter int TAP_W = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  output logic                       run_o,
  output logic                       restart_o,
  output logic [H_W-1:0]             hmax_o,
  output logic [V_W-1:0]             vact_o,
  output logic [V_W-1:0]             vmax_o,
  output logic [NWIN-1:0][H_W-1:0]   win_start_o,
  output logic [NWIN-1:0][H_W-1:0]   win_end_o,
  output logic [H_W-1:0]             act_o,
  output logic                       rv_en_o
);
  localparam int TAPC_W = TAP_W + 1;

  logic                     stop_q;
  logic [H_W-1:0]           hmax_q;
  logic [V_W-1:0]           vact_q, vmax_q;
  logic [NWIN-1:0][H_W-1:0] ws_q, wend_q;
  logic [H_W-1:0]           width_q;
  logic [TAP_W-1:0]         tapf_q;
  logic                     rven_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q  <= 1'b1;
      hmax_q  <= '0;
      vact_q  <= '0;
      vmax_q  <= '0;
      ws_q    <= '0;
      wend_q  <= '0;
      width_q <= '0;
      tapf_q  <= '0;
      rven_q  <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CTRL:  stop_q  <= wdata_i[STOP_BIT];
        ADDR_HMAX:  hmax_q  <= wdata_i[H_W-1:0];
        ADDR_VACT:  vact_q  <= wdata_i[V_W-1:0];
        ADDR_VMAX:  vmax_q  <= wdata_i[V_W-1:0];
        ADDR_WIDTH: width_q <= wdata_i[H_W-1:0];
        ADDR_PATH:  tapf_q  <= wdata_i[TAP_LSB +: TAP_W];
        ADDR_MODE:  rven_q  <= wdata_i[RVSEL_BIT];
        default: ;
      endcase
      for (int i = 0; i < NWIN; i++) begin
        if (addr_i == ADDR_W'(WIN_BASE + 2 * i))     ws_q[i]   <= wdata_i[H_W-1:0];
        if (addr_i == ADDR_W'(WIN_BASE + 2 * i + 1)) wend_q[i] <= wdata_i[H_W-1:0];
      end
    end
  end

  // tap count = field + 1, zero guarded to one
  logic [TAPC_W-1:0] taps_raw, taps;
  assign taps_raw = {1'b0, tapf_q} + TAPC_W'(1);
  assign taps     = (taps_raw == '0) ? TAPC_W'(1) : taps_raw;
  assign act_o    = width_q / {{(H_W-TAPC_W){1'b0}}, taps};

  logic [DW-1:0] hblank, vblank;
  assign hblank = DW'(hmax_q) + DW'(1) - DW'(act_o);
  assign vblank = DW'(vmax_q) - DW'(vact_q);

  always_comb begin
    case (addr_i)
      ADDR_CTRL:  rdata_o = DW'(stop_q) << STOP_BIT;
      ADDR_HMAX:  rdata_o = DW'(hmax_q);
      ADDR_VACT:  rdata_o = DW'(vact_q);
      ADDR_VMAX:  rdata_o = DW'(vmax_q);
      ADDR_WIDTH: rdata_o = DW'(width_q);
      ADDR_PATH:  rdata_o = DW'(tapf_q) << TAP_LSB;
      ADDR_MODE:  rdata_o = DW'(rven_q) << RVSEL_BIT;
      ADDR_HBLK:  rdata_o = hblank;
      ADDR_VBLK:  rdata_o = vblank;
      default:    rdata_o = '0;
    endcase
    for (int i = 0; i < NWIN; i++) begin
      if (addr_i == ADDR_W'(WIN_BASE + 2 * i))     rdata_o = DW'(ws_q[i]);
      if (addr_i == ADDR_W'(WIN_BASE + 2 * i + 1)) rdata_o = DW'(wend_q[i]);
    end
  end

  assign run_o       = ~stop_q;
  assign restart_o   = we_i && (addr_i == ADDR_CTRL);
  assign hmax_o      = hmax_q;
  assign vact_o      = vact_q;
  assign vmax_o      = vmax_q;
  assign win_start_o = ws_q;
  assign win_end_o   = wend_q;
  assign rv_en_o     = rven_q;
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           restart_i,
  input  logic [H_W-1:0] hmax_i,
  input  logic [V_W-1:0] vmax_i,
  output logic [H_W-1:0] h_o,
  output logic [V_W-1:0] v_o
);
  logic [H_W-1:0] h_q;
  logic [V_W-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (restart_i || !run_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q >= hmax_i) begin
      h_q <= '0;
      v_q <= (v_q >= vmax_i) ? '0 : v_q + V_W'(1);
    end else begin
      h_q <= h_q + H_W'(1);
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int H_W = 12
) (
  input  logic [H_W-1:0] h_i,
  input  logic [H_W-1:0] start_i,
  input  logic [H_W-1:0] end_i,
  input  logic [H_W-1:0] act_i,
  output logic           open_o,
  output logic           before_end_o,
  output logic           valid_o,
  output logic           hit_o
);
  logic [H_W:0] end_eff;

  // end of zero means start plus one line of active clocks
  assign end_eff      = (end_i == '0) ? ({1'b0, start_i} + {1'b0, act_i}) : {1'b0, end_i};
  assign open_o       = h_i >= start_i;
  assign before_end_o = {1'b0, h_i} < end_eff;
  assign valid_o      = {1'b0, start_i} < end_eff;
  assign hit_o        = open_o && before_end_o;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int DW    = 16,
  parameter int TAP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [H_W-1:0]    h_cnt_o,
  output logic [V_W-1:0]    v_cnt_o,
  output logic              fval_o,
  output logic              lval_o,
  output logic              rval_o,
  output logic              dval_o
);
  logic                     run, restart, rv_en;
  logic [H_W-1:0]           hmax, act;
  logic [V_W-1:0]           vact, vmax;
  logic [NWIN-1:0][H_W-1:0] win_start, win_end;
  logic [NWIN-1:0]          w_open, w_before, w_valid, w_hit;

  rtg_regs #(.H_W(H_W), .V_W(V_W), .DW(DW), .TAP_W(TAP_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .run_o       (run),
    .restart_o   (restart),
    .hmax_o      (hmax),
    .vact_o      (vact),
    .vmax_o      (vmax),
    .win_start_o (win_start),
    .win_end_o   (win_end),
    .act_o       (act),
    .rv_en_o     (rv_en)
  );

  rtg_counters #(.H_W(H_W), .V_W(V_W)) i_counters (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (restart),
    .hmax_i    (hmax),
    .vmax_i    (vmax),
    .h_o       (h_cnt_o),
    .v_o       (v_cnt_o)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    rtg_window #(.H_W(H_W)) i_win (
      .h_i          (h_cnt_o),
      .start_i      (win_start[g]),
      .end_i        (win_end[g]),
      .act_i        (act),
      .open_o       (w_open[g]),
      .before_end_o (w_before[g]),
      .valid_o      (w_valid[g]),
      .hit_o        (w_hit[g])
    );
  end

  logic line_act;
  assign line_act = v_cnt_o <= vact;
  assign lval_o   = run && line_act && w_hit[WIN_LV];
  assign rval_o   = run && line_act && w_hit[WIN_RV];
  assign dval_o   = rv_en ? rval_o : lval_o;

  // frame strobe: rises on line 0, falls on the last active line
  always_comb begin
    fval_o = 1'b0;
    if (run && w_valid[WIN_FV]) begin
      if (vact == '0)         fval_o = (v_cnt_o == '0) && w_hit[WIN_FV];
      else if (v_cnt_o == '0) fval_o = w_open[WIN_FV];
      else if (v_cnt_o < vact) fval_o = 1'b1;
      else if (v_cnt_o == vact) fval_o = w_before[WIN_FV];
    end
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run_i,
  input logic           we_i,
  input logic [H_W-1:0] h_i,
  input logic [V_W-1:0] v_i,
  input logic [H_W-1:0] hmax_i,
  input logic [V_W-1:0] vmax_i,
  input logic [V_W-1:0] vact_i,
  input logic           fv_i,
  input logic           lv_i,
  input logic           rv_i,
  input logic           dv_i,
  input logic           rv_en_i
);
  p_hstep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !we_i && h_i < hmax_i) |=> h_i == H_W'($past(h_i) + H_W'(1)));

  p_hwrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !we_i && h_i >= hmax_i) |=> h_i == '0);

  p_vhold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !we_i && h_i < hmax_i) |=> $stable(v_i));

  p_vwrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !we_i && h_i >= hmax_i && v_i >= vmax_i) |=> v_i == '0);

  p_active_lines_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv_i || rv_i) |-> v_i <= vact_i);

  p_dv_select_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_i |-> (rv_en_i ? rv_i : lv_i));

  p_stopped_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (h_i == '0 && v_i == '0 && !fv_i && !lv_i && !rv_i && !dv_i));
endmodule

bind raster_timing_gen rtg_checker #(.H_W(H_W), .V_W(V_W)) i_rtg_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run),
  .we_i    (reg_we_i),
  .h_i     (h_cnt_o),
  .v_i     (v_cnt_o),
  .hmax_i  (hmax),
  .vmax_i  (vmax),
  .vact_i  (vact),
  .fv_i    (fval_o),
  .lv_i    (lval_o),
  .rv_i    (rval_o),
  .dv_i    (dval_o),
  .rv_en_i (rv_en)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [11:0] h_cnt_o, v_cnt_o;
  logic        fval_o, lval_o, rval_o, dval_o;

  int n_checks = 0;
  int n_fail   = 0;

  // model of programmed state
  int m_hmax, m_vact, m_vmax, m_width, m_tapf, m_rven;
  int m_s[3];
  int m_e[3];

  raster_timing_gen i_raster_timing_gen (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input int addr, input int data);
    reg_we_i    = 1'b1;
    reg_addr_i  = 4'(addr);
    reg_wdata_i = 16'(data);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    case (addr)
      1: m_hmax = data;
      2: m_vact = data;
      3: m_vmax = data;
      4, 6, 8: m_s[(addr-4)/2] = data;
      5, 7, 9: m_e[(addr-5)/2] = data;
      10: m_width = data;
      11: m_tapf = (data >> 4) & 3;
      12: m_rven = data & 1;
      default: ;
    endcase
  endtask

  task automatic rd(input int addr, input int exp, input string req);
    reg_addr_i = 4'(addr);
    #1;
    check(req, int'(reg_rdata_o), exp);
  endtask

  function automatic int act_clks();
    return m_width / (m_tapf + 1);
  endfunction

  function automatic int eff_end(input int i);
    return (m_e[i] == 0) ? m_s[i] + act_clks() : m_e[i];
  endfunction

  function automatic int in_win(input int i, input int h);
    return (h >= m_s[i] && h < eff_end(i)) ? 1 : 0;
  endfunction

  // {fv,lv,rv,dv}
  function automatic int exp_strb(input int h, input int v);
    int fv, lv, rv, dv;
    lv = (v <= m_vact) ? in_win(1, h) : 0;
    rv = (v <= m_vact) ? in_win(2, h) : 0;
    dv = m_rven ? rv : lv;
    fv = 0;
    if (m_s[0] < eff_end(0)) begin
      if (m_vact == 0)      fv = (v == 0) ? in_win(0, h) : 0;
      else if (v == 0)      fv = (h >= m_s[0]) ? 1 : 0;
      else if (v < m_vact)  fv = 1;
      else if (v == m_vact) fv = (h < eff_end(0)) ? 1 : 0;
    end
    return fv * 8 + lv * 4 + rv * 2 + dv;
  endfunction

  function automatic int act_strb();
    return int'({fval_o, lval_o, rval_o, dval_o});
  endfunction

  // starts at the falling edge right after a restart write
  task automatic scan(input int n, input string tag);
    int eh = 0;
    int ev = 0;
    for (int i = 0; i < n; i++) begin
      check({tag, " R1 hcount"}, int'(h_cnt_o), eh);
      check({tag, " R2 vcount"}, int'(v_cnt_o), ev);
      check({tag, " R3 R4 R6 R7 R8 strobes"}, act_strb(), exp_strb(eh, ev));
      if (eh >= m_hmax) begin
        eh = 0;
        ev = (ev >= m_vmax) ? 0 : ev + 1;
      end else eh++;
      @(negedge clk_i);
    end
  endtask

  task automatic check_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      check({tag, " R10 h"}, int'(h_cnt_o), 0);
      check({tag, " R10 v"}, int'(v_cnt_o), 0);
      check({tag, " R10 strobes"}, act_strb(), 0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    check_idle(4, "reset");
    rd(0, 8, "R10 ctrl after reset");
  endtask

  task automatic base_cfg();
    wr(10, 8); wr(11, 16'h00); wr(1, 9); wr(2, 2); wr(3, 4);
    wr(4, 1); wr(5, 0); wr(6, 1); wr(7, 0); wr(8, 2); wr(9, 6); wr(12, 0);
  endtask

  task automatic t_basic();
    base_cfg();
    wr(0, 0);
    scan(100, "basic");
    rd(13, 2, "R9 hblank");
    rd(14, 2, "R9 vblank");
    rd(5, 0, "R4 raw end kept");
  endtask

  task automatic t_taps();
    wr(11, 16'h10);
    rd(13, 6, "R5 hblank two taps");
    wr(0, 0);
    scan(60, "two taps R5");
    wr(11, 16'h30);
    rd(13, 8, "R5 hblank four taps");
    wr(0, 0);
    scan(60, "four taps R5");
    wr(11, 16'h00);
  endtask

  task automatic t_rv_mode();
    wr(8, 3); wr(9, 7); wr(12, 1);
    wr(0, 0);
    scan(100, "rv mode R8");
    wr(12, 0);
  endtask

  task automatic t_empty_win();
    wr(6, 5); wr(7, 3); wr(8, 4); wr(9, 4); wr(4, 6); wr(5, 2);
    wr(0, 0);
    scan(50, "empty R3");
  endtask

  task automatic t_single_line();
    base_cfg();
    wr(2, 0); wr(4, 2); wr(5, 5); wr(6, 2); wr(7, 0);
    rd(14, 4, "R9 vblank single line");
    wr(0, 0);
    scan(50, "single line R7");
  endtask

  task automatic t_stop();
    base_cfg();
    wr(0, 0);
    scan(23, "pre stop");
    wr(0, 8);
    check_idle(5, "stopped");
    wr(1, 6);
    wr(6, 0);
    check_idle(3, "stopped after writes");
    rd(0, 8, "R10 ctrl stopped");
    wr(0, 0);
    scan(70, "restart R10");
  endtask

  initial begin
    m_hmax = 0; m_vact = 0; m_vmax = 0; m_width = 0; m_tapf = 0; m_rven = 0;
    for (int i = 0; i < 3; i++) begin m_s[i] = 0; m_e[i] = 0; end
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    @(negedge clk_i);
    t_basic();
    t_taps();
    t_rv_mode();
    t_empty_win();
    t_single_line();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule